// File: doc/BRIEF.md
# LED Print Head Line Controller

This block feeds one raster line at a time into the serial shift register of an LED print head. A line transfer starts when a line-sync pulse arrives while the page-sync window is open. The block pulls dots from a valid/ready stream and sends them out one per head clock. The frame is longer than the line, so the block pads it with zero-data clocks. When the last clock has gone out, it raises a latch pulse, which copies the shifted line into the head's output register.

Once the latch pulse ends, the four active-low strobe outputs fire one after another, never two at once, so that the four LED groups light in four time slices. Each strobe lasts a configurable number of system clock cycles. Because the head latch isolates the output register from the shift register, the next line may shift in while the current line's strobes are still running. If that next line finishes shifting first, its latch waits until every strobe has ended.

Dots that are not ready when a slot needs one are replaced by zero, so nothing prints in error, and a one-cycle underrun pulse reports each such slot.

Top module: `ledhead_line_ctrl`

## Requirements
- R1: A line transfer starts only on a `lineSync` pulse seen while `pageSync` is high and no transfer is in progress. A `lineSync` with `pageSync` low, or during a transfer, has no effect.
- R2: The first rising edge of `headClk` comes HALF_PER+1 clock edges after the edge that samples `lineSync`. After that, the rising edges are 2*HALF_PER cycles apart, and `headClk` is high for HALF_PER cycles of each bit.
- R3: Every transfer has exactly FRAME_CLKS rising edges of `headClk`. At rising edge k (from 0), `headData` holds the k-th dot slot for k < LINE_DOTS, and 0 for LINE_DOTS <= k < FRAME_CLKS.
- R4: `headLatch` rises HALF_PER cycles after the last rising edge of `headClk`, unless a strobe is still active. It stays high for LATCH_CYC cycles, and `headClk` is low throughout.
- R5: The strobes go low in order: index 0, 1, 2, 3 of `headStrobeN`.
  - Strobe 0 falls on the edge where `headLatch` falls.
  - Each later strobe falls on the edge where the previous one rises.
  - Each strobe is low for `strobeWidth` cycles. A width of 0 is treated as 1. The width is sampled when the sequence starts.
  - At most one strobe is low at any time.
- R6: `dotReady` is high for exactly one cycle at the start of each of the first LINE_DOTS bit slots. A dot is consumed only when `dotValid` is high in that cycle. If `dotValid` is low, the slot carries 0, `underrun` pulses for one cycle on the next cycle, and the stream does not advance.
- R7: A new line may start and shift while strobes are active. Its latch is held off until all strobes are high, and then rises one cycle after the last strobe rises.
- R8: After reset:
  - `headClk`, `headData`, `headLatch`, `dotReady` and `underrun` are 0.
  - All four bits of `headStrobeN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageSync | input | 1 | High while the page window is active |
| lineSync | input | 1 | One-cycle line start pulse |
| strobeWidth | input | SW_W | Strobe length in system cycles (0 means 1) |
| dotData | input | 1 | Dot value from the line stream |
| dotValid | input | 1 | Stream has a dot available |
| dotReady | output | 1 | Block takes a dot in this cycle |
| headData | output | 1 | Serial dot data to the head |
| headClk | output | 1 | Head shift clock |
| headLatch | output | 1 | Line latch pulse |
| headStrobeN | output | 4 | Active-low LED group strobes |
| underrun | output | 1 | One-cycle pulse when a dot slot found no data |

## Verification
Every timed result is defined as an exact number of clock edges after a known event:
- the first head clock rise, HALF_PER+1 edges after the sampled line-sync;
- each later rise, 2*HALF_PER edges after the previous one;
- the latch, HALF_PER edges after the last rise;
- each strobe, at the latch fall or at the previous strobe's rise;
- the deferred latch, one edge after the last strobe rises;
- each underrun pulse, one cycle after the starved ready cycle.

The bench drives inputs just after a rising edge and records every output transition at the falling edge, stamped with an edge counter. It then compares those stamps and the captured bits with values computed from the parameters and the chosen patterns.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_WAIT, SH_LATCH} shState_t;

  typedef struct packed {
    logic takeDot;
    logic padBit;
  } lhcStrobe_t;
endpackage

// File: rtl/lhc_seq_ctrl.sv
module lhc_seq_ctrl
  import lhc_pkg::*;
#(
  parameter int LINE_DOTS  = 2496,
  parameter int FRAME_CLKS = 2560,
  parameter int HALF_PER   = 20,
  parameter int LATCH_CYC  = 60,
  parameter int NUM_STB    = 4,
  parameter int SW_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pageSync,
  input  logic             lineSync,
  input  logic [SW_W-1:0]  strobeWidth,
  output lhcStrobe_t       ctrl,
  output logic             headClk,
  output logic             headLatch,
  output logic [NUM_STB-1:0] headStrobeN
);
  localparam int BIT_W = $clog2(FRAME_CLKS);
  localparam int PH_W  = $clog2(2 * HALF_PER);
  localparam int LT_W  = (LATCH_CYC > 1) ? $clog2(LATCH_CYC) : 1;
  localparam int IX_W  = (NUM_STB > 1) ? $clog2(NUM_STB) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_CLKS - 1);
  localparam logic [BIT_W-1:0] DOTS_L   = BIT_W'(LINE_DOTS);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(2 * HALF_PER - 1);
  localparam logic [PH_W-1:0]  HALF_L   = PH_W'(HALF_PER);
  localparam logic [LT_W-1:0]  LAST_LT  = LT_W'(LATCH_CYC - 1);
  localparam logic [IX_W-1:0]  LAST_IX  = IX_W'(NUM_STB - 1);

  shState_t         st;
  logic [BIT_W-1:0] bitCnt;
  logic [PH_W-1:0]  phase;
  logic [LT_W-1:0]  latchCnt;
  logic             stbActive;
  logic [IX_W-1:0]  stbIdx;
  logic [SW_W-1:0]  stbCnt;
  logic [SW_W-1:0]  stbW;
  logic             startStb;
  logic             slotStart;

  assign slotStart    = (st == SH_RUN) && (phase == '0);
  assign ctrl.takeDot = slotStart && (bitCnt < DOTS_L);
  assign ctrl.padBit  = slotStart && (bitCnt >= DOTS_L);
  assign startStb     = (st == SH_LATCH) && (latchCnt == LAST_LT);

  // Shift / latch sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= SH_IDLE;
      bitCnt    <= '0;
      phase     <= '0;
      latchCnt  <= '0;
      headClk   <= 1'b0;
      headLatch <= 1'b0;
    end else begin
      headClk <= (st == SH_RUN) && (phase >= HALF_L);
      unique case (st)
        SH_IDLE: begin
          if (lineSync && pageSync) begin
            st     <= SH_RUN;
            phase  <= '0;
            bitCnt <= '0;
          end
        end
        SH_RUN: begin
          if (phase == LAST_PH) begin
            phase <= '0;
            if (bitCnt == LAST_BIT) st <= SH_WAIT;
            else                    bitCnt <= bitCnt + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        SH_WAIT: begin
          if (!stbActive) begin
            st        <= SH_LATCH;
            latchCnt  <= '0;
            headLatch <= 1'b1;
          end
        end
        SH_LATCH: begin
          if (latchCnt == LAST_LT) begin
            st        <= SH_IDLE;
            headLatch <= 1'b0;
          end else begin
            latchCnt <= latchCnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Time-divided strobe sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbActive <= 1'b0;
      stbIdx    <= '0;
      stbCnt    <= '0;
      stbW      <= SW_W'(1);
    end else if (startStb) begin
      stbActive <= 1'b1;
      stbIdx    <= '0;
      stbCnt    <= '0;
      stbW      <= (strobeWidth == '0) ? SW_W'(1) : strobeWidth;
    end else if (stbActive) begin
      if (stbCnt == stbW - 1'b1) begin
        stbCnt <= '0;
        if (stbIdx == LAST_IX) stbActive <= 1'b0;
        else                   stbIdx    <= stbIdx + 1'b1;
      end else begin
        stbCnt <= stbCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign headStrobeN[g] = !(stbActive && (stbIdx == IX_W'(g)));
  end
endmodule

// File: rtl/lhc_shift_path.sv
module lhc_shift_path
  import lhc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lhcStrobe_t ctrl,
  input  logic       dotData,
  input  logic       dotValid,
  output logic       dotReady,
  output logic       headData,
  output logic       underrun
);
  assign dotReady = ctrl.takeDot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headData <= 1'b0;
      underrun <= 1'b0;
    end else if (ctrl.takeDot) begin
      headData <= dotValid && dotData;
      underrun <= !dotValid;
    end else begin
      underrun <= 1'b0;
      if (ctrl.padBit) headData <= 1'b0;
    end
  end
endmodule

// File: rtl/ledhead_line_ctrl.sv
module ledhead_line_ctrl
  import lhc_pkg::*;
#(
  parameter int LINE_DOTS  = 2496,
  parameter int FRAME_CLKS = 2560,
  parameter int HALF_PER   = 20,
  parameter int LATCH_CYC  = 60,
  parameter int SW_W       = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pageSync,
  input  logic            lineSync,
  input  logic [SW_W-1:0] strobeWidth,
  input  logic            dotData,
  input  logic            dotValid,
  output logic            dotReady,
  output logic            headData,
  output logic            headClk,
  output logic            headLatch,
  output logic [3:0]      headStrobeN,
  output logic            underrun
);
  lhcStrobe_t ctrl;

  lhc_seq_ctrl #(
    .LINE_DOTS(LINE_DOTS), .FRAME_CLKS(FRAME_CLKS), .HALF_PER(HALF_PER),
    .LATCH_CYC(LATCH_CYC), .NUM_STB(4), .SW_W(SW_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .pageSync(pageSync), .lineSync(lineSync),
    .strobeWidth(strobeWidth), .ctrl(ctrl), .headClk(headClk),
    .headLatch(headLatch), .headStrobeN(headStrobeN)
  );

  lhc_shift_path path_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dotData(dotData),
    .dotValid(dotValid), .dotReady(dotReady), .headData(headData),
    .underrun(underrun)
  );
endmodule

// File: rtl/lhc_checker.sv
module lhc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       dotReady,
  input logic       dotValid,
  input logic       headClk,
  input logic       headLatch,
  input logic [3:0] headStrobeN,
  input logic       underrun
);
  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~headStrobeN));

  a_r5_first_after_latch: assert property (@(posedge clk) disable iff (!rstN)
    $fell(headStrobeN[0]) |-> $past(headLatch));

  a_r7_latch_waits_strobes: assert property (@(posedge clk) disable iff (!rstN)
    headLatch |-> (&headStrobeN));

  a_r4_clk_low_in_latch: assert property (@(posedge clk) disable iff (!rstN)
    headLatch |-> !headClk);

  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    dotReady |=> !dotReady);

  a_r6_underrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(dotReady && !dotValid));
endmodule

bind ledhead_line_ctrl lhc_checker chk_i (
  .clk(clk), .rstN(rstN), .dotReady(dotReady), .dotValid(dotValid),
  .headClk(headClk), .headLatch(headLatch), .headStrobeN(headStrobeN),
  .underrun(underrun)
);

// File: tb/ledhead_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module ledhead_line_ctrl_tb_top;
  localparam int DOTS = 20;
  localparam int FRAME = 24;
  localparam int HALF = 2;
  localparam int LC = 3;
  localparam int SW_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pageSync = 1'b0;
  logic lineSync = 1'b0;
  logic [SW_W-1:0] strobeWidth = '0;
  logic dotData, dotValid, dotReady, headData, headClk, headLatch, underrun;
  logic [3:0] headStrobeN;

  always #2.5 clk = ~clk;

  ledhead_line_ctrl #(.LINE_DOTS(DOTS), .FRAME_CLKS(FRAME), .HALF_PER(HALF),
    .LATCH_CYC(LC), .SW_W(SW_W)) dut_i (
    .clk(clk), .rstN(rstN), .pageSync(pageSync), .lineSync(lineSync),
    .strobeWidth(strobeWidth), .dotData(dotData), .dotValid(dotValid),
    .dotReady(dotReady), .headData(headData), .headClk(headClk),
    .headLatch(headLatch), .headStrobeN(headStrobeN), .underrun(underrun));

  int tests = 0, fails = 0, cyc = 0;
  logic [63:0] pat = '0, slotValid = '1, bitsGot = '0;
  int j = 0, slotIdx = 0, riseCount = 0, firstRise = 0, lastRise = 0, periodErr = 0;
  int latchCount = 0, latchRise = 0, latchFall = 0, latchLen = 0, latchStbErr = 0;
  int stbFall[4], stbLen[4];
  int stbRises = 0, lastStbRise = 0, overlapErr = 0, clkLatchErr = 0;
  int readyCount = 0, underrunCount = 0;
  logic pendAdv = 0, pendValid = 0, prevClk = 0, prevLatch = 0;
  logic [3:0] prevStb = 4'hF;

  assign dotData  = pat[j[5:0]];
  assign dotValid = slotValid[slotIdx[5:0]];

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor: samples away from the active edge
  always @(negedge clk) begin
    if (pendAdv) begin
      if (pendValid) j++;
      slotIdx++;
      pendAdv = 0;
    end
    if (dotReady) begin readyCount++; pendAdv = 1; pendValid = dotValid; end
    if (underrun) underrunCount++;
    if (headClk && !prevClk) begin
      if (riseCount < 64) bitsGot[riseCount] = headData;
      if (riseCount == 0) firstRise = cyc;
      else if (cyc - lastRise != 2 * HALF) periodErr++;
      lastRise = cyc;
      riseCount++;
    end
    if (headLatch && !prevLatch) begin
      latchRise = cyc; latchCount++;
      if (!(&headStrobeN)) latchStbErr++;
    end
    if (!headLatch && prevLatch) begin latchFall = cyc; latchLen = cyc - latchRise; end
    for (int i = 0; i < 4; i++) begin
      if (!headStrobeN[i] && prevStb[i]) stbFall[i] = cyc;
      if (headStrobeN[i] && !prevStb[i]) begin
        stbLen[i] = cyc - stbFall[i]; stbRises++; lastStbRise = cyc;
      end
    end
    if ($countones(~headStrobeN) > 1) overlapErr++;
    if (headLatch && headClk) clkLatchErr++;
    prevClk = headClk; prevLatch = headLatch; prevStb = headStrobeN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLine();
    j = 0; slotIdx = 0; riseCount = 0; periodErr = 0; bitsGot = '0;
    readyCount = 0; underrunCount = 0; pendAdv = 0;
  endtask

  task automatic clearStb();
    stbRises = 0; overlapErr = 0; latchStbErr = 0; clkLatchErr = 0; latchCount = 0;
  endtask

  // Issues a line-sync pulse; returns the edge index that samples it
  task automatic pulseLine(output int e0);
    @(posedge clk); #1;
    lineSync = 1'b1; e0 = cyc + 1;
    @(posedge clk); #1;
    lineSync = 1'b0;
  endtask

  task automatic waitFor(ref int cnt, input int target);
    int guard = 0;
    while (cnt < target && guard < 5000) begin @(posedge clk); guard++; end
    #1;
  endtask

  function automatic int expBits(output logic [63:0] eb);
    int jj = 0, inval = 0;
    eb = '0;
    for (int k = 0; k < DOTS; k++) begin
      if (slotValid[k]) begin eb[k] = pat[jj]; jj++; end
      else inval++;
    end
    return inval;
  endfunction

  task automatic checkShift(input int e0);
    logic [63:0] eb;
    int inval, mism = 0;
    inval = expBits(eb);
    for (int k = 0; k < FRAME; k++) if (bitsGot[k] !== eb[k]) mism++;
    check(riseCount == FRAME, "R3 rise count", riseCount, FRAME);
    check(mism == 0, "R3 bit mismatches", mism, 0);
    check(firstRise == e0 + 1 + HALF, "R2 first rise edge", firstRise, e0 + 1 + HALF);
    check(periodErr == 0, "R2 bit period errors", periodErr, 0);
    check(readyCount == DOTS, "R6 ready pulses", readyCount, DOTS);
    check(underrunCount == inval, "R6 underrun pulses", underrunCount, inval);
  endtask

  task automatic runLine(input int w, input logic [63:0] p, input logic [63:0] v,
                         input bit midSync);
    int e0, ew, dummy;
    ew = (w == 0) ? 1 : w;
    pat = p; slotValid = v; strobeWidth = SW_W'(w);
    clearLine(); clearStb();
    pulseLine(e0);
    if (midSync) begin
      repeat (FRAME * HALF) @(posedge clk);
      pulseLine(dummy);
    end
    waitFor(stbRises, 4);
    repeat (4) @(posedge clk);
    #1;
    checkShift(e0);
    check(latchCount == 1, "R1 one latch per line", latchCount, 1);
    check(latchRise == lastRise + HALF, "R4 latch rise edge", latchRise, lastRise + HALF);
    check(latchLen == LC, "R4 latch width", latchLen, LC);
    check(clkLatchErr == 0, "R4 clock in latch", clkLatchErr, 0);
    check(stbFall[0] == latchFall, "R5 strobe0 at latch fall", stbFall[0], latchFall);
    for (int i = 0; i < 4; i++) begin
      check(stbLen[i] == ew, "R5 strobe width", stbLen[i], ew);
      check(stbFall[i] == latchFall + i * ew, "R5 strobe order", stbFall[i], latchFall + i * ew);
    end
    check(overlapErr == 0, "R5 strobe overlap", overlapErr, 0);
  endtask

  initial begin
    int e1, e2, firstRise2, stbEnd1;
    fork
      begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check(headClk == 0 && headData == 0 && headLatch == 0, "R8 head outputs idle", int'({headClk, headData, headLatch}), 0);
    check(headStrobeN == 4'hF, "R8 strobes high", int'(headStrobeN), 15);
    check(dotReady == 0 && underrun == 0, "R8 stream idle", int'({dotReady, underrun}), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R1: line sync outside page window is ignored
    clearLine(); clearStb();
    pulseLine(e1);
    repeat (150) @(posedge clk);
    #1;
    check(riseCount == 0, "R1 no clocks without page", riseCount, 0);
    check(latchCount == 0 && readyCount == 0, "R1 no latch without page", latchCount + readyCount, 0);

    pageSync = 1'b1;
    // Sweep strobe widths and dot patterns
    runLine(1, 64'hA5C3_9E17_0F0F_5A5A, '1, 0);
    runLine(3, 64'h0000_0000_000F_FFFF, '1, 0);
    runLine(0, 64'h1234_5678_9ABC_DEF0, '1, 0);
    runLine(6, 64'hFFFF_FFFF_FFFF_FFFF, '1, 0);
    // R6: starved slots give zero and underrun
    runLine(2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFF7_6FFE, 0);
    runLine(2, 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_5555_5555_5555, 0);
    // R1: sync during transfer ignored
    runLine(2, 64'h0F1E_2D3C_4B5A_6978, '1, 1);

    // R7: next line shifts during strobes; latch deferred
    pat = 64'h3C3C_3C3C_3C3C_3C3C; slotValid = '1; strobeWidth = SW_W'(40);
    clearLine(); clearStb();
    pulseLine(e1);
    waitFor(stbRises, 0);
    while (latchCount < 1 || headLatch) begin @(posedge clk); #1; end
    clearLine();
    pat = 64'h6969_6969_6969_6969;
    pulseLine(e2);
    waitFor(stbRises, 4);
    stbEnd1 = lastStbRise;
    waitFor(latchCount, 2);
    firstRise2 = firstRise;
    check(firstRise2 < stbEnd1, "R7 shifting overlaps strobes", firstRise2, stbEnd1);
    check(latchRise == stbEnd1 + 1, "R7 deferred latch edge", latchRise, stbEnd1 + 1);
    check(latchStbErr == 0, "R7 latch during strobe", latchStbErr, 0);
    checkShift(e2);
    waitFor(stbRises, 8);
    check(overlapErr == 0, "R5 strobe overlap in overlap run", overlapErr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule